// File: doc/BRIEF.md
# Interlocked Dual-Bus Ownership Arbiter

This block decides which of two independent buses a bridge device holds: a backplane bus (index 0) and an expansion bus (index 1). Each bus has its own request output and grant input, and the device owns a bus when its request and that bus's grant are both high. Local logic asks for a bus with an acquire strobe and gives one up with a release strobe. The arbitration protocol inside each bus is not part of this block.

An interlock mode bit, written through a small strobe-and-value pair, changes how releases are handled. With interlock on, the device never gives up its last owned bus. A release first raises the request on the other bus and waits for that bus's grant. Only then is the old request dropped, so both buses are owned for at least one cycle and ownership is never empty. If interlock is on and nothing is requested, the arbiter asks for the backplane bus by itself. With interlock off, releases take effect at once, even if that leaves the device owning nothing.

Two synchronous active-low resets are provided. The hard reset clears everything, including the mode bit. The soft reset clears the requests and any pending handover but keeps the mode bit.

Top module: `dual_bus_arbiter`

## Requirements
- R1: A hard reset (hard_rst_n low at a clock edge) clears the interlock mode bit, both requests and handover_busy. After it, no request rises by itself.
- R2: A soft reset clears both requests and handover_busy and leaves the mode bit as it was. If interlock was on, the backplane request (bit 0) rises one edge after the soft reset is released.
- R3: A mode write takes effect at the clock edge that samples it. In interlock mode, when neither request is high, the next edge raises bus_req[0] (the backplane).
- R4: bus_owned[i] is high exactly when bus_req[i] and bus_gnt[i] are both high. Index 0 is the backplane bus and index 1 is the expansion bus.
- R5: In interlock mode, releasing an owned bus while the other bus is not owned raises the other request and handover_busy at the next edge. The old request stays high until the edge after the other bus's grant is seen, at which point it and handover_busy drop. With a grant latency of L cycles, handover_busy is high for L+1 cycles.
- R6: In interlock mode, as long as the grants stay high while requested, bus_owned never returns to zero once one bus is owned.
- R7: In interlock mode, releasing a bus while the other bus is already owned drops its request at the next edge, and no handover starts.
- R8: In interlock mode, at most one release is acted on per cycle, with the backplane taking priority. A release of a bus that is not requested is ignored, and so is a release when neither bus is owned.
- R9: With interlock off, a release drops that bus's request at the next edge, and an acquire raises it. If both arrive for the same bus in the same cycle, the release wins. The device may end up owning no bus.
- R10: Turning interlock off during a handover drops the request of the bus being released and clears handover_busy within two edges of the mode write.
- R11: In interlock mode, an acquire outside a handover raises that bus's request at the next edge. Acquires and releases that arrive while a handover is pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Synchronous active-low hard reset; clears everything |
| soft_rst_n | input | 1 | Synchronous active-low soft reset; keeps the mode bit |
| mode_wr_en | input | 1 | Strobe that loads the interlock mode bit |
| mode_wr_val | input | 1 | Value loaded into the mode bit |
| acq_req | input | 2 | Per-bus acquire strobe (0 backplane, 1 expansion) |
| rel_req | input | 2 | Per-bus release strobe |
| bus_gnt | input | 2 | Per-bus grant from each bus's arbiter |
| bus_req | output | 2 | Per-bus request line |
| bus_owned | output | 2 | Per-bus ownership (request and grant) |
| handover_busy | output | 1 | High while an interlocked handover waits for the other grant |

## Verification
The bench sweeps the grant latency of the destination bus from 0 to 4 cycles, in both handover directions. At every cycle it checks that ownership is never empty and that the busy window lasts exactly latency plus one cycles. A design that dropped the old request one cycle early would show a cycle with no owned bus. A design that dropped it late would stretch the busy window. Simultaneous releases of both owned buses are checked for backplane priority; a design that honoured both would drop to zero ownership. Releases during a handover, with nothing owned, or after the mode is switched off are also checked, along with the difference between soft and hard reset: keeping the mode bit through a hard reset, or losing it on a soft reset, shows up as a backplane request that appears or fails to appear.

// File: rtl/arb_pkg.sv
// Shared constants and types for the dual-bus ownership arbiter.
// Assumes exactly two buses: index 0 is the backplane, index 1 the expansion bus.
package arb_pkg;
    localparam int NUM_BUS = 2;
    localparam int BUS_BP  = 0;
    localparam int BUS_XP  = 1;

    typedef logic [NUM_BUS-1:0] bus_vec_t;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_HANDOVER = 1'b1
    } ho_state_e;
endpackage

// File: rtl/arb_mode_reg.sv
// Holds the interlock mode bit.
// Assumes: only the hard reset clears it; the soft reset is deliberately not wired here.
module arb_mode_reg (
    input  logic clk,
    input  logic hard_rst_n,
    input  logic wr_en,
    input  logic wr_val,
    output logic mode_q
);
    // Load the mode bit on a write strobe; clear it on hard reset only.
    always_ff @(posedge clk) begin
        if (!hard_rst_n) begin
            mode_q <= 1'b0;
        end else if (wr_en) begin
            mode_q <= wr_val;
        end
    end
endmodule

// File: rtl/arb_req_slot.sv
// One bus's request flop plus its ownership term.
// Assumes: a clear has priority over a set in the same cycle.
module arb_req_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic gnt_i,
    output logic req_o,
    output logic own_o
);
    // Request register: reset, then clear, then set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o <= 1'b0;
        end else if (clr_i) begin
            req_o <= 1'b0;
        end else if (set_i) begin
            req_o <= 1'b1;
        end
    end

    // The bus is owned when it is both requested and granted.
    assign own_o = req_o & gnt_i;
endmodule

// File: rtl/arb_handover_fsm.sv
// Decides the per-bus set/clear strobes and tracks a pending interlocked handover.
// Assumes: two buses; the grant of a requested bus stays high until the request drops.
module arb_handover_fsm
    import arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     mode_i,
    input  bus_vec_t acq_i,
    input  bus_vec_t rel_i,
    input  bus_vec_t req_i,
    input  bus_vec_t own_i,
    output bus_vec_t set_o,
    output bus_vec_t clr_o,
    output logic     busy_o
);
    ho_state_e st_q, st_d;
    logic      src_q, src_d;
    logic      taken;

    // Next-state and strobe decode for both modes.
    always_comb begin
        set_o = '0;
        clr_o = '0;
        st_d  = st_q;
        src_d = src_q;
        taken = 1'b0;
        if (!mode_i) begin
            // Free mode: releases act at once and win over acquires.
            st_d  = ST_IDLE;
            clr_o = rel_i;
            set_o = acq_i & ~rel_i;
            if (st_q == ST_HANDOVER) begin
                clr_o[src_q] = 1'b1;
            end
        end else if (st_q == ST_HANDOVER) begin
            // Wait for the destination bus before letting go of the source.
            if (own_i[~src_q]) begin
                clr_o[src_q] = 1'b1;
                st_d         = ST_IDLE;
            end
        end else begin
            set_o = acq_i;
            if (req_i == '0) begin
                set_o[BUS_BP] = 1'b1;
            end
            for (int i = 0; i < NUM_BUS; i++) begin
                if (!taken && rel_i[i] && req_i[i]) begin
                    taken = 1'b1;
                    if (own_i[NUM_BUS-1-i]) begin
                        clr_o[i] = 1'b1;
                    end else if (own_i[i]) begin
                        set_o[NUM_BUS-1-i] = 1'b1;
                        st_d               = ST_HANDOVER;
                        src_d              = 1'(i);
                    end
                end
            end
        end
    end

    // State and source-bus registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            src_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            src_q <= src_d;
        end
    end

    assign busy_o = (st_q == ST_HANDOVER);
endmodule

// File: rtl/dual_bus_arbiter.sv
// Top of the interlocked dual-bus ownership arbiter.
// Assumes: both resets synchronous active-low; bus grants are held while requested.
module dual_bus_arbiter
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       hard_rst_n,
    input  logic       soft_rst_n,
    input  logic       mode_wr_en,
    input  logic       mode_wr_val,
    input  logic [1:0] acq_req,
    input  logic [1:0] rel_req,
    input  logic [1:0] bus_gnt,
    output logic [1:0] bus_req,
    output logic [1:0] bus_owned,
    output logic       handover_busy
);
    logic     rst_n;
    logic     mode_q;
    bus_vec_t set_s, clr_s;

    // Either reset clears the request path; only hard reset reaches the mode bit.
    assign rst_n = hard_rst_n & soft_rst_n;

    arb_mode_reg u_mode (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .wr_en      (mode_wr_en),
        .wr_val     (mode_wr_val),
        .mode_q     (mode_q)
    );

    arb_handover_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_q),
        .acq_i  (acq_req),
        .rel_i  (rel_req),
        .req_i  (bus_req),
        .own_i  (bus_owned),
        .set_o  (set_s),
        .clr_o  (clr_s),
        .busy_o (handover_busy)
    );

    for (genvar g = 0; g < NUM_BUS; g++) begin : g_slot
        arb_req_slot u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_s[g]),
            .clr_i (clr_s[g]),
            .gnt_i (bus_gnt[g]),
            .req_o (bus_req[g]),
            .own_o (bus_owned[g])
        );
    end
endmodule

// File: rtl/arb_checker.sv
// Property checker for dual_bus_arbiter, attached by bind.
// Assumes: the environment holds each grant high while its request is high.
module arb_checker (
    input logic       clk,
    input logic       hard_rst_n,
    input logic       soft_rst_n,
    input logic       mode_wr_en,
    input logic       mode,
    input logic [1:0] rel_req,
    input logic [1:0] bus_req,
    input logic [1:0] bus_owned
);
    AST_OWNERSHIP_KEPT: assert property (@(posedge clk) disable iff (!hard_rst_n || !soft_rst_n)
        (mode && (bus_owned != 2'b00)) |=> (!mode || (bus_owned != 2'b00))); // R6
    AST_BP_HELD: assert property (@(posedge clk) disable iff (!hard_rst_n || !soft_rst_n)
        (mode && bus_req[0] && !bus_owned[1]) |=> bus_req[0]); // R5
    AST_XP_HELD: assert property (@(posedge clk) disable iff (!hard_rst_n || !soft_rst_n)
        (mode && bus_req[1] && !bus_owned[0]) |=> bus_req[1]); // R5
    AST_IDLE_PICKS_BP: assert property (@(posedge clk) disable iff (!hard_rst_n || !soft_rst_n)
        (mode && (bus_req == 2'b00)) |=> bus_req[0]); // R3
    AST_SOFT_KEEPS_MODE: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (!soft_rst_n && !mode_wr_en) |=> $stable(mode)); // R2
    AST_FREE_RELEASE_BP: assert property (@(posedge clk) disable iff (!hard_rst_n || !soft_rst_n)
        (!mode && rel_req[0]) |=> !bus_req[0]); // R9
    AST_FREE_RELEASE_XP: assert property (@(posedge clk) disable iff (!hard_rst_n || !soft_rst_n)
        (!mode && rel_req[1]) |=> !bus_req[1]); // R9
endmodule

bind dual_bus_arbiter arb_checker i_arb_checker (
    .clk        (clk),
    .hard_rst_n (hard_rst_n),
    .soft_rst_n (soft_rst_n),
    .mode_wr_en (mode_wr_en),
    .mode       (mode_q),
    .rel_req    (rel_req),
    .bus_req    (bus_req),
    .bus_owned  (bus_owned)
);

// File: tb/test_dual_bus_arbiter.sv
// Self-checking bench: a grant model with per-bus latency, handover sweeps, reset and mode corners.
module test_dual_bus_arbiter;
    logic       clk = 1'b0;
    logic       hard_rst_n = 1'b0;
    logic       soft_rst_n = 1'b0;
    logic       mode_wr_en = 1'b0;
    logic       mode_wr_val = 1'b0;
    logic [1:0] acq_req = 2'b00;
    logic [1:0] rel_req = 2'b00;
    logic [1:0] bus_gnt = 2'b00;
    logic [1:0] bus_req;
    logic [1:0] bus_owned;
    logic       handover_busy;

    int total = 0;
    int bad = 0;
    int lat [2] = '{1, 1};
    int gcnt [2] = '{0, 0};

    always #2 clk = ~clk;

    dual_bus_arbiter i_dual_bus_arbiter (
        .clk           (clk),
        .hard_rst_n    (hard_rst_n),
        .soft_rst_n    (soft_rst_n),
        .mode_wr_en    (mode_wr_en),
        .mode_wr_val   (mode_wr_val),
        .acq_req       (acq_req),
        .rel_req       (rel_req),
        .bus_gnt       (bus_gnt),
        .bus_req       (bus_req),
        .bus_owned     (bus_owned),
        .handover_busy (handover_busy)
    );

    // Bus model: the grant follows the request after lat[i] cycles and drops with it.
    always begin
        @(posedge clk);
        #1;
        for (int i = 0; i < 2; i++) begin
            if (!bus_req[i]) begin
                bus_gnt[i] = 1'b0;
                gcnt[i]    = 0;
            end else if (gcnt[i] >= lat[i]) begin
                bus_gnt[i] = 1'b1;
            end else begin
                gcnt[i]++;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_mode(input logic v);
        mode_wr_en  = 1'b1;
        mode_wr_val = v;
        step(1);
        mode_wr_en  = 1'b0;
    endtask

    // Interlocked handover from bus src with destination grant latency L (R5, R6, R4).
    task automatic handover(input int src, input int L);
        int busy_n = 0;
        int empty_n = 0;
        int dst = 1 - src;
        lat[dst] = L;
        rel_req[src] = 1'b1;
        step(1);
        rel_req[src] = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (handover_busy) busy_n++;
            if (bus_owned == 2'b00) empty_n++;
            if (!handover_busy) break;
            step(1);
        end
        chk("R5 busy cycles", busy_n, L + 1);
        chk("R6 empty ownership cycles", empty_n, 0);
        chk("R4 owner after handover", int'(bus_owned), 1 << dst);
    endtask

    initial begin
        step(2);
        chk("R1 req in reset", int'(bus_req), 0);
        chk("R1 busy in reset", int'(handover_busy), 0);
        hard_rst_n = 1'b1;
        soft_rst_n = 1'b1;
        step(2);
        chk("R1 no request after reset", int'(bus_req), 0);

        // Free mode acquire and release (R9, R4).
        acq_req = 2'b10;
        step(1);
        acq_req = 2'b00;
        chk("R9 acquire sets request", int'(bus_req), 2);
        step(3);
        chk("R4 owned after grant", int'(bus_owned), 2);
        acq_req = 2'b10;
        rel_req = 2'b10;
        step(1);
        acq_req = 2'b00;
        rel_req = 2'b00;
        chk("R9 release wins, nothing owned", int'(bus_req), 0);

        // Mode on with nothing requested (R3).
        lat[0] = 0;
        write_mode(1'b1);
        chk("R3 no request yet at mode edge", int'(bus_req), 0);
        step(1);
        chk("R3 backplane requested", int'(bus_req), 1);
        chk("R4 backplane owned", int'(bus_owned), 1);

        // Handover sweep over grant latency, both directions (R5, R6).
        for (int L = 0; L < 5; L++) begin
            handover(0, L);
            handover(1, L);
        end

        // Both owned, both released together (R11, R7, R8).
        lat[1] = 1;
        acq_req = 2'b10;
        step(1);
        acq_req = 2'b00;
        chk("R11 acquire in mode", int'(bus_req), 3);
        step(3);
        chk("R4 both owned", int'(bus_owned), 3);
        rel_req = 2'b11;
        step(1);
        rel_req = 2'b00;
        chk("R8 backplane release only", int'(bus_req), 2);
        chk("R7 no handover when other owned", int'(handover_busy), 0);

        // Release during handover is ignored (R11).
        lat[0] = 6;
        rel_req = 2'b10;
        step(1);
        chk("R5 busy starts", int'(handover_busy), 1);
        rel_req = 2'b10;
        step(1);
        rel_req = 2'b00;
        chk("R11 release ignored in handover", int'(bus_req), 3);
        for (int k = 0; k < 20; k++) begin
            if (!handover_busy) break;
            step(1);
        end
        chk("R5 handover to backplane done", int'(bus_owned), 1);

        // Mode off during a handover (R10, R9).
        lat[1] = 20;
        rel_req = 2'b01;
        step(1);
        rel_req = 2'b00;
        chk("R10 handover pending", int'(handover_busy), 1);
        write_mode(1'b0);
        step(1);
        chk("R10 source request dropped", int'(bus_req), 2);
        chk("R10 busy cleared", int'(handover_busy), 0);
        rel_req = 2'b10;
        step(1);
        rel_req = 2'b00;
        chk("R9 nothing owned allowed", int'(bus_owned), 0);

        // Release with nothing owned in mode is ignored (R8).
        lat[0] = 10;
        write_mode(1'b1);
        step(1);
        chk("R3 backplane requested again", int'(bus_req), 1);
        rel_req = 2'b01;
        step(1);
        rel_req = 2'b00;
        chk("R8 release of unowned bus ignored", int'(bus_req), 1);

        // Soft reset keeps the mode bit (R2).
        soft_rst_n = 1'b0;
        step(1);
        soft_rst_n = 1'b1;
        chk("R2 soft reset clears requests", int'(bus_req), 0);
        step(1);
        chk("R2 mode kept after soft reset", int'(bus_req), 1);

        // Hard reset clears the mode bit (R1).
        hard_rst_n = 1'b0;
        step(1);
        hard_rst_n = 1'b1;
        chk("R1 hard reset clears requests", int'(bus_req), 0);
        step(3);
        chk("R1 mode cleared by hard reset", int'(bus_req), 0);
        chk("R1 busy clear", int'(handover_busy), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule